// File: doc/BRIEF.md
# Soft Mute Ramp Sequencer

This block sits in the sample path in front of a DAC. It scales each incoming signed sample by a gain that steps linearly between unity and zero, and it raises a hard-mute flag once the gain has reached zero and a fixed settling delay has passed. A mute is requested by pulling the active-low mute input low, or by the clock-error input going high. Each ramp step is taken on a sample strobe, so the ramp length is fixed in samples and a faster sample rate gives a proportionally shorter mute.

While the clock-error input is high, the block ignores the live input and replays the last sample it took in while the clock was healthy, decaying that held value toward zero. After the gain reaches zero, a free-running microsecond tick times the settling interval before hard mute asserts. When the request is withdrawn, hard mute drops at once and the gain climbs back to unity one step per strobe. A request that changes direction mid-ramp continues from the current gain and never jumps.

Top module: `soft_mute_ramp`

## Requirements
- R1: During and right after reset, `smp_out` is 0, `hard_mute` is 0 and the gain is unity.
- R2: With no mute request, each strobe registers the input sample unchanged; `smp_out` shows it from the cycle after the strobe.
- R3: With a mute request (`mute_n` = 0 or `clk_err` = 1), each strobe lowers the gain by one of `STEPS` (default 150) equal steps, and `smp_out` becomes the source sample times the new gain divided by `STEPS`, truncated toward zero.
- R4: Starting from unity, `STEPS` strobes under a mute request bring `smp_out` to 0.
- R5: `hard_mute` asserts only after `HOLD_US` (default 200) `us_tick` pulses have been counted with the gain at zero and the request still present; it asserts in the cycle after the last counted tick.
- R6: While `hard_mute` is 1, `smp_out` is 0 regardless of strobes and input samples.
- R7: While `clk_err` is 1 the live input is ignored; the source is the last sample taken on a strobe while `clk_err` was 0.
- R8: When `mute_n` is 1 and `clk_err` is 0, `hard_mute` drops in the next cycle and the gain rises by one step per strobe up to unity; with `clk_err` still 1, `hard_mute` stays asserted.
- R9: A change of request direction mid-ramp continues from the present gain; the gain never moves by more than one step per cycle.
- R10: Between strobes, `smp_out` and the gain hold their values whatever `smp_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| smp_in | input | DW | Signed input sample |
| mute_n | input | 1 | Active-low mute request |
| clk_err | input | 1 | Audio clock error flag; also requests mute |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| smp_out | output | DW | Signed gain-scaled sample |
| hard_mute | output | 1 | Hard mute flag |

## Verification
The bench reverses a down-ramp part way and checks the next outputs; a design that restarted from unity or zero would produce a plainly wrong product. It counts ticks up to one short of the settling interval and then the final one, which exposes an off-by-one or a flag raised as soon as the gain hits zero. It sends a clock error with a very different live sample, so a design that scaled the live input instead of the held one gives the wrong value. It also shows that hard mute persists while the clock error remains after the mute input is released, and checks that small negative products truncate toward zero, not toward minus infinity.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DW      = 16,
  parameter int STEPS   = 150,
  parameter int HOLD_US = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] smp_in,
  input  logic                 mute_n,
  input  logic                 clk_err,
  input  logic                 us_tick,
  output logic signed [DW-1:0] smp_out,
  output logic                 hard_mute
);
  localparam int GW = $clog2(STEPS + 1);
  localparam int TW = $clog2(HOLD_US + 1);
  localparam int PW = DW + GW + 1;

  logic [GW-1:0]        gain, gain_nxt;
  logic [TW-1:0]        tmr;
  logic signed [DW-1:0] held, out_q, src, scaled;
  logic signed [PW-1:0] prod;
  logic                 mute_req;

  assign mute_req = !mute_n || clk_err;
  assign src      = clk_err ? held : smp_in;

  always_comb begin
    gain_nxt = gain;
    if (mute_req && gain != '0)
      gain_nxt = gain - GW'(1);
    else if (!mute_req && gain != GW'(STEPS))
      gain_nxt = gain + GW'(1);
  end

  assign prod    = PW'(src) * $signed({1'b0, gain_nxt});
  assign scaled  = DW'(prod / $signed(PW'(STEPS)));
  assign smp_out = hard_mute ? '0 : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain      <= GW'(STEPS);
      out_q     <= '0;
      held      <= '0;
      tmr       <= '0;
      hard_mute <= 1'b0;
    end else begin
      if (smp_stb) begin
        gain  <= gain_nxt;
        out_q <= scaled;
        if (!clk_err) held <= smp_in;
      end
      if (!mute_req) begin
        hard_mute <= 1'b0;
        tmr       <= '0;
      end else if (gain == '0 && !hard_mute && us_tick) begin
        if (tmr == TW'(HOLD_US - 1)) begin
          hard_mute <= 1'b1;
          tmr       <= '0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 mute_n,
  input logic                 clk_err,
  input logic                 us_tick,
  input logic                 hard_mute,
  input logic signed [DW-1:0] smp_out,
  input logic [GW-1:0]        gain
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && (!mute_n || clk_err) && gain != '0 |=> gain == $past(gain) - GW'(1));

  p_no_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (gain == $past(gain) || gain == $past(gain) + GW'(1) || gain == $past(gain) - GW'(1)));

  p_hard_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hard_mute |-> gain == '0);

  p_hard_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(hard_mute) |-> $past(us_tick));

  p_hard_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(hard_mute) |-> $past(mute_n) && !$past(clk_err));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(smp_stb) && !hard_mute && !$past(hard_mute) |-> $stable(smp_out));
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mute_n(mute_n),
  .clk_err(clk_err), .us_tick(us_tick), .hard_mute(hard_mute),
  .smp_out(smp_out), .gain(gain)
);

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;
  localparam int DW = 16;
  localparam int NV = 11;
  localparam int V_MUTE [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam int V_IN   [NV] = '{1000, -32768, 32767, -1, 15000, 30000, -300, 7, -7, 150, -150};
  localparam int V_EXP  [NV] = '{1000, -32768, 32767, -1, 14900, 29600, -294, 6, -6, 146, -147};

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, mute_n = 1'b1, clk_err = 1'b0, us_tick = 1'b0;
  logic signed [DW-1:0] smp_in = '0;
  logic signed [DW-1:0] smp_out;
  logic hard_mute;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  soft_mute_ramp #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in), .mute_n(mute_n),
    .clk_err(clk_err), .us_tick(us_tick), .smp_out(smp_out), .hard_mute(hard_mute)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int s);
    @(negedge clk); smp_in = DW'(s); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); us_tick = 1'b1;
    @(negedge clk); us_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out", int'(smp_out), 0);
    chk("R1 hard", int'(hard_mute), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after", int'(smp_out), 0);

    for (int i = 0; i < NV; i++) begin
      mute_n = V_MUTE[i][0];
      strobe(V_IN[i]);
      chk(i < 4 ? "R2 unity" : (i < 9 ? "R3 ramp" : "R9 reverse"), int'(smp_out), V_EXP[i]);
    end

    mute_n = 1'b0;
    for (int k = 0; k < 100; k++) strobe(20000);
    chk("R3 gain 47", int'(smp_out), 6266);
    for (int k = 0; k < 47; k++) strobe(20000);
    chk("R4 zero", int'(smp_out), 0);
    chk("R5 not yet", int'(hard_mute), 0);
    for (int k = 0; k < 199; k++) tick();
    chk("R5 199 ticks", int'(hard_mute), 0);
    tick();
    chk("R5 200 ticks", int'(hard_mute), 1);
    strobe(5000);
    chk("R6 forced zero", int'(smp_out), 0);

    @(negedge clk); mute_n = 1'b1;
    @(negedge clk);
    chk("R8 release", int'(hard_mute), 0);
    strobe(3000);
    chk("R8 up 1", int'(smp_out), 20);
    strobe(3000);
    chk("R8 up 2", int'(smp_out), 40);
    smp_in = -5000;
    repeat (5) @(negedge clk);
    chk("R10 hold", int'(smp_out), 40);

    for (int k = 0; k < 148; k++) strobe(9000);
    chk("R8 unity", int'(smp_out), 9000);
    strobe(1234);
    chk("R2 last good", int'(smp_out), 1234);
    clk_err = 1'b1;
    strobe(-20000);
    chk("R7 held 1", int'(smp_out), 1225);
    strobe(-20000);
    chk("R7 held 2", int'(smp_out), 1217);
    for (int k = 0; k < 148; k++) strobe(-20000);
    chk("R7 decayed", int'(smp_out), 0);
    for (int k = 0; k < 200; k++) tick();
    chk("R5 clk err hard", int'(hard_mute), 1);
    repeat (4) @(negedge clk);
    chk("R8 err holds hard", int'(hard_mute), 1);
    clk_err = 1'b0;
    @(negedge clk);
    chk("R8 err cleared", int'(hard_mute), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule